// File: doc/BRIEF.md
# Opcode-Qualified Address Comparator

This block is one debug comparator. It watches the CPU bus address and flags a hit when that address equals a programmed compare address. A read/write check can be added so that only reads or only writes count. The comparator can be switched off as a whole.

A trigger-select control chooses what counts as a trigger. When it is clear, the plain address match is the trigger in the same cycle. When it is set, the match must first travel through a small model of the instruction queue. A matching opcode fetch places a one-bit tag in the queue. The tag moves one step forward on each queue advance. The trigger fires only when the tagged entry reaches the head and the CPU executes it. A change of flow flushes the queue, so an opcode that was fetched but then thrown away never fires. Each comparator has its own tag queue, so several comparators can follow different instructions at the same time.

Top module: `opq_comparator`

## Requirements
- R1: `raw_hit` is high in the same cycle that `cmp_en` is 1 and `bus_addr` equals `cmp_addr`. When `rw_chk_en` is 1, `bus_rw` must also equal `rw_val`. When `rw_chk_en` is 0, `bus_rw` is ignored.
- R2: When `trig_sel` is 0, `qual_hit` equals `raw_hit` in the same cycle.
- R3: When `trig_sel` is 1, a cycle with `raw_hit`, `bus_fetch` and `q_adv` all high loads a tag into queue entry 0. The tag reaches the head (entry `QDEPTH-1`) after `QDEPTH-1` further advances. `qual_hit` is high in any cycle where `q_exec` is 1 and the head holds a tag.
- R4: When `trig_sel` is 1, an address match without `bus_fetch` (a data access) never causes `qual_hit`.
- R5: Tags move only on a cycle with `q_adv` high. Without an advance they keep their places, so an execute before the tag reaches the head gives no `qual_hit`.
- R6: A cycle with `q_flush` high clears every tag. Flush has priority over advance and load.
- R7: When `cmp_en` is 0, `raw_hit` and `qual_hit` are low and all tags are cleared on the next clock edge.
- R8: After a synchronous active-low reset, no tag is held. With `trig_sel` set to 1, `qual_hit` stays low while executes happen.
- R9: Tags in different queue entries are tracked independently. Two matching fetches in a row give two `qual_hit` pulses, one on each execute as each tag reaches the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_en | input | 1 | Comparator enable |
| trig_sel | input | 1 | 1 = trigger needs opcode tracking |
| rw_chk_en | input | 1 | 1 = match also needs `bus_rw == rw_val` |
| rw_val | input | 1 | Programmed read/write value |
| cmp_addr | input | ADDR_W | Programmed compare address |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_rw | input | 1 | CPU bus read/write strobe |
| bus_fetch | input | 1 | Current bus cycle is an opcode fetch |
| q_adv | input | 1 | Instruction queue advances one entry |
| q_exec | input | 1 | Queue head is executed this cycle |
| q_flush | input | 1 | Change of flow: the queue is discarded |
| raw_hit | output | 1 | Qualified address match, same cycle |
| qual_hit | output | 1 | Trigger condition |

## Verification
The address match is tried with an equal address, an address one bit away, and the read/write check switched on and off. These cases tell an address failure apart from a read/write filter failure. In tracking mode the bench sends a single matching fetch, a matching data access, a fetch followed by an early execute, a flush in mid-flight, and two fetches in a row. Together they separate the conditions for loading a tag, the shift timing, the priority of flush, and independent tracking in each entry. Turning `cmp_en` off while a tag is in the queue shows that both outputs are forced low and that the stale tag cannot fire after the comparator is switched back on.

// File: rtl/opq_pkg.sv
// Package opq_pkg
// What it does: holds the shared default sizes for the opcode-qualified comparator.
// What it assumes: the queue is at least two entries deep.
package opq_pkg;
    parameter int OPQ_ADDR_W = 16;
    parameter int OPQ_QDEPTH = 3;

    // Selects which match drives the trigger output.
    typedef enum logic {
        TRIG_DIRECT  = 1'b0,
        TRIG_TRACKED = 1'b1
    } trig_src_e;
endpackage

// File: rtl/opq_addr_match.sv
// Module opq_addr_match
// What it does: compares the bus address (and, if asked, the R/W strobe)
//               against the programmed values.
// What it assumes: all inputs are settled within the cycle; no state is kept.
module opq_addr_match #(
    parameter int ADDR_W = opq_pkg::OPQ_ADDR_W
) (
    input  logic              en,
    input  logic              rw_chk_en,
    input  logic              rw_val,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rw,
    output logic              hit
);
    logic addr_eq;
    logic rw_ok;

    // Address equality and the optional R/W filter.
    always_comb begin
        addr_eq = (bus_addr == cmp_addr);
        rw_ok   = !rw_chk_en || (bus_rw == rw_val);
        hit     = en && addr_eq && rw_ok;
    end
endmodule

// File: rtl/opq_tag_queue.sv
// Module opq_tag_queue
// What it does: models the instruction queue as one tag bit per entry. A tag
//               is loaded at entry 0 on an advance, shifts toward the head on
//               each advance, and reports a hit when the head is executed.
// What it assumes: flush and disable override advance; depth is at least 2.
module opq_tag_queue #(
    parameter int DEPTH = opq_pkg::OPQ_QDEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic flush,
    input  logic adv,
    input  logic load,
    input  logic exec,
    output logic head_hit
);
    localparam int HEAD = DEPTH - 1;

    logic [DEPTH-1:0] tags;
    logic [DEPTH-1:0] tags_nxt;

    // Next-state shift network, one stage per queue entry.
    assign tags_nxt[0] = load;
    genvar gi;
    generate
        for (gi = 1; gi < DEPTH; gi++) begin : g_stage
            assign tags_nxt[gi] = tags[gi-1];
        end
    endgenerate

    // Tag register update: reset, clear on flush or disable, shift on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || flush) begin
            tags <= '0;
        end else if (adv) begin
            tags <= tags_nxt;
        end
    end

    // Head entry executed while it holds a tag.
    assign head_hit = en && exec && tags[HEAD];

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tags == '0)); // R6

    AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flush && !adv) |=> $stable(tags)); // R5

    AST_HEAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flush && adv) |=> (tags[HEAD] == $past(tags[HEAD-1]))); // R3

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tags == '0)); // R7
endmodule

// File: rtl/opq_trig_select.sv
// Module opq_trig_select
// What it does: picks the direct match or the tracked match as the trigger.
// What it assumes: both inputs are already gated by the comparator enable.
module opq_trig_select (
    input  logic sel,
    input  logic direct_hit,
    input  logic tracked_hit,
    output logic trig
);
    // Source mux driven by the trigger-select control.
    always_comb begin
        unique case (opq_pkg::trig_src_e'(sel))
            opq_pkg::TRIG_TRACKED: trig = tracked_hit;
            default:               trig = direct_hit;
        endcase
    end
endmodule

// File: rtl/opq_comparator.sv
// Module opq_comparator
// What it does: one debug comparator with an optional R/W check and optional
//               opcode tracking of the matched fetch through the instruction queue.
// What it assumes: bus_fetch marks opcode fetches; the CPU drives q_adv,
//                  q_exec and q_flush in step with its own queue.
module opq_comparator #(
    parameter int ADDR_W = opq_pkg::OPQ_ADDR_W,
    parameter int QDEPTH = opq_pkg::OPQ_QDEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic              trig_sel,
    input  logic              rw_chk_en,
    input  logic              rw_val,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rw,
    input  logic              bus_fetch,
    input  logic              q_adv,
    input  logic              q_exec,
    input  logic              q_flush,
    output logic              raw_hit,
    output logic              qual_hit
);
    logic match;
    logic tracked;
    logic tag_load;

    opq_addr_match #(.ADDR_W(ADDR_W)) i_match (
        .en        (cmp_en),
        .rw_chk_en (rw_chk_en),
        .rw_val    (rw_val),
        .cmp_addr  (cmp_addr),
        .bus_addr  (bus_addr),
        .bus_rw    (bus_rw),
        .hit       (match)
    );

    // A tag is loaded only for a matching opcode fetch.
    assign tag_load = match && bus_fetch;

    opq_tag_queue #(.DEPTH(QDEPTH)) i_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cmp_en),
        .flush    (q_flush),
        .adv      (q_adv),
        .load     (tag_load),
        .exec     (q_exec),
        .head_hit (tracked)
    );

    opq_trig_select i_sel (
        .sel         (trig_sel),
        .direct_hit  (match),
        .tracked_hit (tracked),
        .trig        (qual_hit)
    );

    assign raw_hit = match;

    AST_RW_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_chk_en && (bus_rw != rw_val)) |-> !raw_hit); // R1

    AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_sel |-> (qual_hit == raw_hit)); // R2

    AST_TRACKED_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel && qual_hit) |-> q_exec); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |-> (!raw_hit && !qual_hit)); // R7
endmodule

// File: tb/test_opq_comparator.sv
module test_opq_comparator;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmp_en, trig_sel, rw_chk_en, rw_val;
    logic [AW-1:0] cmp_addr, bus_addr;
    logic          bus_rw, bus_fetch, q_adv, q_exec, q_flush;
    logic          raw_hit, qual_hit;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    opq_comparator i_opq_comparator (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .trig_sel(trig_sel),
        .rw_chk_en(rw_chk_en), .rw_val(rw_val), .cmp_addr(cmp_addr),
        .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_fetch(bus_fetch),
        .q_adv(q_adv), .q_exec(q_exec), .q_flush(q_flush),
        .raw_hit(raw_hit), .qual_hit(qual_hit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock; inputs are then driven 2 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        bus_addr = 16'h0000; bus_rw = 1'b1; bus_fetch = 1'b0;
        q_adv = 1'b0; q_exec = 1'b0; q_flush = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cmp_en = 1'b1; trig_sel = 1'b1; rw_chk_en = 1'b0;
        rw_val = 1'b1; cmp_addr = 16'h1234; idle();
        tick(); tick();
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            q_exec = 1'b1; q_adv = 1'b1; settle();
            check("R8 reset no tag", qual_hit, 1'b0);
            tick();
        end
        idle();
    endtask

    task automatic t_raw_match();
        trig_sel = 1'b0; rw_chk_en = 1'b0;
        bus_addr = 16'h1234; bus_rw = 1'b0; settle();
        check("R1 equal addr, rw ignored", raw_hit, 1'b1);
        bus_addr = 16'h1235; settle();
        check("R1 addr differs", raw_hit, 1'b0);
        bus_addr = 16'h1234; rw_chk_en = 1'b1; rw_val = 1'b1; bus_rw = 1'b0; settle();
        check("R1 rw mismatch", raw_hit, 1'b0);
        bus_rw = 1'b1; settle();
        check("R1 rw match", raw_hit, 1'b1);
        check("R2 direct trigger", qual_hit, 1'b1);
        bus_addr = 16'h0234; settle();
        check("R2 direct trigger low", qual_hit, 1'b0);
        rw_chk_en = 1'b0; tick(); idle();
    endtask

    // Load a matching fetch, then advance twice so the tag is at the head.
    task automatic load_to_head();
        bus_addr = 16'h1234; bus_fetch = 1'b1; q_adv = 1'b1; tick();
        idle(); q_adv = 1'b1; tick();
        q_adv = 1'b1; tick();
        idle();
    endtask

    task automatic t_tracked();
        trig_sel = 1'b1;
        bus_addr = 16'h1234; bus_fetch = 1'b1; settle();
        check("R3 no trigger at fetch", qual_hit, 1'b0);
        load_to_head();
        settle();
        check("R3 head tagged, no exec", qual_hit, 1'b0);
        q_exec = 1'b1; settle();
        check("R3 exec of tagged head", qual_hit, 1'b1);
        tick(); idle(); q_adv = 1'b1; tick(); idle();
        q_exec = 1'b1; settle();
        check("R3 tag shifted out", qual_hit, 1'b0);
        tick(); idle();
    endtask

    task automatic t_data_access();
        trig_sel = 1'b1;
        bus_addr = 16'h1234; bus_fetch = 1'b0; q_adv = 1'b1; settle();
        check("R4 data access raw match", raw_hit, 1'b1);
        tick(); idle();
        for (int k = 0; k < 3; k++) begin
            q_adv = 1'b1; q_exec = 1'b1; settle();
            check("R4 data access no trigger", qual_hit, 1'b0);
            tick();
        end
        idle();
    endtask

    task automatic t_hold();
        trig_sel = 1'b1;
        bus_addr = 16'h1234; bus_fetch = 1'b1; q_adv = 1'b1; tick(); idle();
        q_adv = 1'b1; tick(); idle();
        for (int k = 0; k < 4; k++) begin
            q_exec = 1'b1; settle();
            check("R5 early exec without advance", qual_hit, 1'b0);
            tick();
        end
        idle(); q_adv = 1'b1; tick(); idle();
        q_exec = 1'b1; settle();
        check("R5 tag held then reaches head", qual_hit, 1'b1);
        tick(); idle(); q_flush = 1'b1; tick(); idle();
    endtask

    task automatic t_flush();
        trig_sel = 1'b1;
        bus_addr = 16'h1234; bus_fetch = 1'b1; q_adv = 1'b1; tick(); idle();
        q_adv = 1'b1; q_flush = 1'b1; tick(); idle();
        q_adv = 1'b1; tick(); idle();
        q_exec = 1'b1; settle();
        check("R6 flushed tag", qual_hit, 1'b0);
        tick(); idle();
        bus_addr = 16'h1234; bus_fetch = 1'b1; q_adv = 1'b1; q_flush = 1'b1; tick(); idle();
        q_adv = 1'b1; tick(); q_adv = 1'b1; tick(); idle();
        q_exec = 1'b1; settle();
        check("R6 flush beats load", qual_hit, 1'b0);
        tick(); idle();
    endtask

    task automatic t_disable();
        trig_sel = 1'b0;
        cmp_en = 1'b0; bus_addr = 16'h1234; settle();
        check("R7 raw forced low", raw_hit, 1'b0);
        check("R7 direct qual forced low", qual_hit, 1'b0);
        cmp_en = 1'b1; trig_sel = 1'b1; idle();
        load_to_head();
        cmp_en = 1'b0; q_exec = 1'b1; settle();
        check("R7 tracked qual forced low", qual_hit, 1'b0);
        tick();
        cmp_en = 1'b1; q_exec = 1'b1; settle();
        check("R7 stale tag cleared", qual_hit, 1'b0);
        tick(); idle();
    endtask

    task automatic t_back2back();
        trig_sel = 1'b1;
        bus_addr = 16'h1234; bus_fetch = 1'b1; q_adv = 1'b1; tick();
        tick();
        idle(); q_adv = 1'b1; tick(); idle();
        q_exec = 1'b1; settle();
        check("R9 first tag", qual_hit, 1'b1);
        q_adv = 1'b1; tick(); idle();
        q_exec = 1'b1; settle();
        check("R9 second tag", qual_hit, 1'b1);
        q_adv = 1'b1; tick(); idle();
        q_exec = 1'b1; settle();
        check("R9 queue empty", qual_hit, 1'b0);
        tick(); idle();
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_raw_match();
        t_tracked();
        t_data_access();
        t_hold();
        t_flush();
        t_disable();
        t_back2back();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule